// File: doc/BRIEF.md
# Delta-Panel Horizontal Drive Timing Generator

This block produces the horizontal drive waveforms for a color LCD panel whose dots sit in a delta pattern. It runs from a master dot clock that is four times the shift-clock rate. On each line-start strobe it restarts a master-cycle counter and latches the line's settings. It then issues a start pulse and a burst of complementary two-phase shift clocks. The burst length depends on the aspect mode: 357 shift-clock cycles in 16:9 and 269 in 4:3. Every other line is pushed later by one and a half shift-clock bits, which tracks the 1.5-dot offset between adjacent delta rows.

Besides the clocks, the block drives four more outputs. A per-line video polarity flag flips on every line. A blanking flag covers the time outside the scan window. A side-black window flag marks the unused side areas in 4:3 mode. A registered scan-direction output is passed on to the panel. Aspect and direction are sampled only at the line strobe, so a change in the middle of a line takes effect on the next line.

All durations are parameters counted in master-clock cycles: the lead time from strobe to first shift clock, the shift-clock divider and the two burst lengths.

Top module: `hscan_timing`

## Requirements
- R1: `hck1` and `hck2` are complements of each other in every cycle. Outside the active burst, `hck1` is held low and `hck2` high.
- R2: When `wide_sel` is 1 at the strobe (16:9), the line carries exactly 357 `hck1` pulses. Each pulse is 2 master cycles high followed by 2 low.
- R3: When `wide_sel` is 0 at the strobe (4:3), the line carries exactly 269 `hck1` pulses, with the same 2-high/2-low shape.
- R4: Count k from 0, where k = 0 is the first output cycle after the strobe is sampled. The first `hck1` rise is at k = LEAD (8) on lines with `vid_pol` = 0. On lines with `vid_pol` = 1 it is at k = LEAD + 6, which is 1.5 shift-clock bits later.
- R5: `hst` is high for 4 master cycles. It rises 2 cycles before the first `hck1` rise (setup) and falls 2 cycles after it (hold).
- R6: `vid_pol` inverts once for each sampled strobe and is otherwise stable. It is 0 after reset, so the first line after reset has `vid_pol` = 1.
- R7: `blank` is high from the strobe until the cycle in which `hst` rises. It is low through the last active `hck1` cycle and then high until the next strobe.
- R8: `side_black` equals `blank` on 4:3 lines and is 0 on 16:9 lines.
- R9: `scan_dir` takes the value of `scan_fwd` at the strobe (1 = normal, 0 = reversed). Changes to `scan_fwd` or `wide_sel` between strobes have no effect until the next strobe.
- R10: A strobe arriving mid-line aborts the current burst and restarts the line timing from k = 0.
- R11: During and after reset, before any strobe, the outputs are: `hst` = 0, `hck1` = 0, `hck2` = 1, `blank` = 1, `side_black` = 0, `vid_pol` = 0, `scan_dir` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master dot clock, four times the shift-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 1 | One-cycle pulse that starts a horizontal line |
| wide_sel | input | 1 | Aspect select sampled at the strobe: 1 = 16:9, 0 = 4:3 |
| scan_fwd | input | 1 | Scan direction sampled at the strobe: 1 = normal, 0 = reversed |
| hst | output | 1 | Horizontal start pulse |
| hck1 | output | 1 | Shift clock, phase 1 |
| hck2 | output | 1 | Shift clock, phase 2 (complement of phase 1) |
| blank | output | 1 | High outside the start-pulse-to-last-clock window |
| side_black | output | 1 | Side-black window flag, active on 4:3 lines only |
| vid_pol | output | 1 | Line polarity flag, also selects the delayed lines |
| scan_dir | output | 1 | Latched scan direction for the panel |

## Verification
Every output is registered from the next-state counter. The edge that samples the strobe therefore already presents the k = 0 values, and a result for position k is due exactly k + 1 edges after the strobe edge. The bench drives inputs on the falling edge and advances its behavioural line model on the rising edge. It compares all seven outputs at the following falling edge, so each sample lines up with the same k as the design. Per-line totals of `hck1` rises and the position of the first rise are checked at the end of each line. The mid-line aspect and direction toggles are checked through the same per-cycle comparison on the lines that follow them.

// File: rtl/hscan_pkg.sv
package hscan_pkg;

    // Settings captured at each line strobe
    typedef struct packed {
        logic odd;   // line parity; 1 selects the delayed (offset) line
        logic wide;  // 1 = 16:9 burst length, 0 = 4:3
        logic fwd;   // scan direction handed to the panel
    } line_mode_t;

    // Horizontal drive bundle
    typedef struct packed {
        logic hst;
        logic hck1;
        logic hck2;
        logic blank;
        logic side_black;
        logic vid_pol;
        logic dir;
    } hdrv_t;

    localparam hdrv_t HDRV_IDLE = '{hst: 1'b0, hck1: 1'b0, hck2: 1'b1, blank: 1'b1,
                                    side_black: 1'b0, vid_pol: 1'b0, dir: 1'b1};

endpackage

// File: rtl/hscan_line_seq.sv
module hscan_line_seq
    import hscan_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int CNT_MAX = 1443
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe,
    input  logic             wide_sel,
    input  logic             scan_fwd,
    output logic [CNT_W-1:0] cnt_nxt,
    output line_mode_t       mode_nxt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        line_mode_t       mode;
    } seq_t;

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (line_strobe) begin
            seq_d.cnt       = '0;
            seq_d.mode.odd  = ~seq_q.mode.odd;
            seq_d.mode.wide = wide_sel;
            seq_d.mode.fwd  = scan_fwd;
        end else if (seq_q.cnt != CNT_TOP) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.cnt       <= CNT_TOP;
            seq_q.mode.odd  <= 1'b0;
            seq_q.mode.wide <= 1'b1;
            seq_q.mode.fwd  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cnt_nxt  = seq_d.cnt;
    assign mode_nxt = seq_d.mode;

endmodule

// File: rtl/hscan_decode.sv
module hscan_decode
    import hscan_pkg::*;
#(
    parameter int CNT_W    = 11,
    parameter int DIV      = 4,
    parameter int LEAD     = 8,
    parameter int N_WIDE   = 357,
    parameter int N_NARROW = 269
) (
    input  logic [CNT_W-1:0] cnt,
    input  line_mode_t       mode,
    output hdrv_t            drv
);

    localparam int HALF  = DIV / 2;
    localparam int OFF   = DIV + DIV / 2;   // 1.5 shift-clock bits
    localparam int SETUP = DIV / 2;
    localparam int HOLD  = DIV / 2;
    localparam int PH_W  = $clog2(DIV);

    logic [CNT_W-1:0] start_c, stop_c, win_lo_c, hst_hi_c;
    logic [PH_W-1:0]  ph_c;
    logic             act_c, win_c;

    always_comb begin
        start_c  = CNT_W'(LEAD) + (mode.odd ? CNT_W'(OFF) : '0);
        stop_c   = start_c + (mode.wide ? CNT_W'(DIV * N_WIDE) : CNT_W'(DIV * N_NARROW));
        win_lo_c = start_c - CNT_W'(SETUP);
        hst_hi_c = start_c + CNT_W'(HOLD);
        ph_c     = PH_W'(cnt - start_c);
        act_c    = (cnt >= start_c) && (cnt < stop_c);
        win_c    = (cnt >= win_lo_c) && (cnt < stop_c);

        drv.hck1       = act_c && (ph_c < PH_W'(HALF));
        drv.hck2       = ~drv.hck1;
        drv.hst        = (cnt >= win_lo_c) && (cnt < hst_hi_c);
        drv.blank      = ~win_c;
        drv.side_black = ~mode.wide & ~win_c;
        drv.vid_pol    = mode.odd;
        drv.dir        = mode.fwd;
    end

endmodule

// File: rtl/hscan_timing.sv
module hscan_timing
    import hscan_pkg::*;
#(
    parameter int DIV      = 4,
    parameter int LEAD     = 8,
    parameter int N_WIDE   = 357,
    parameter int N_NARROW = 269
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_strobe,
    input  logic wide_sel,
    input  logic scan_fwd,
    output logic hst,
    output logic hck1,
    output logic hck2,
    output logic blank,
    output logic side_black,
    output logic vid_pol,
    output logic scan_dir
);

    localparam int N_MAX   = (N_WIDE > N_NARROW) ? N_WIDE : N_NARROW;
    localparam int CNT_MAX = LEAD + DIV + DIV / 2 + DIV * N_MAX + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_nxt;
    line_mode_t       mode_nxt;
    hdrv_t            drv_c, drv_d, drv_q;

    hscan_line_seq #(
        .CNT_W   (CNT_W),
        .CNT_MAX (CNT_MAX)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_strobe (line_strobe),
        .wide_sel    (wide_sel),
        .scan_fwd    (scan_fwd),
        .cnt_nxt     (cnt_nxt),
        .mode_nxt    (mode_nxt)
    );

    hscan_decode #(
        .CNT_W    (CNT_W),
        .DIV      (DIV),
        .LEAD     (LEAD),
        .N_WIDE   (N_WIDE),
        .N_NARROW (N_NARROW)
    ) u_dec (
        .cnt  (cnt_nxt),
        .mode (mode_nxt),
        .drv  (drv_c)
    );

    always_comb begin
        drv_d = drv_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= HDRV_IDLE;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign hst        = drv_q.hst;
    assign hck1       = drv_q.hck1;
    assign hck2       = drv_q.hck2;
    assign blank      = drv_q.blank;
    assign side_black = drv_q.side_black;
    assign vid_pol    = drv_q.vid_pol;
    assign scan_dir   = drv_q.dir;

endmodule

// File: rtl/hscan_timing_chk.sv
module hscan_timing_chk #(
    parameter int DIV    = 4,
    parameter int N_WIDE = 357
) (
    input logic clk,
    input logic rst_n,
    input logic line_strobe,
    input logic hst,
    input logic hck1,
    input logic hck2,
    input logic blank,
    input logic side_black,
    input logic vid_pol,
    input logic scan_dir
);

    logic [15:0] rise_cnt_q;
    logic [7:0]  hst_run_q;
    logic        hck1_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt_q  <= '0;
            hst_run_q   <= '0;
            hck1_prev_q <= 1'b0;
        end else begin
            hck1_prev_q <= hck1;
            if (line_strobe)
                rise_cnt_q <= '0;
            else if (hck1 && !hck1_prev_q && rise_cnt_q != 16'hFFFF)
                rise_cnt_q <= rise_cnt_q + 1'b1;
            if (hst && hst_run_q != 8'hFF)
                hst_run_q <= hst_run_q + 1'b1;
            else if (!hst)
                hst_run_q <= '0;
        end
    end

    assert_hck_complement_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hck1 != hck2);

    assert_burst_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt_q <= 16'(N_WIDE));

    assert_hst_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hst |-> (hst_run_q < 8'(DIV)));

    assert_hst_unblanked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hst |-> !blank);

    assert_pol_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(line_strobe) |-> (vid_pol != $past(vid_pol)));

    assert_pol_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_strobe) |-> $stable(vid_pol));

    assert_side_black_in_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        side_black |-> blank);

    assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_strobe) |-> $stable(scan_dir));

endmodule

bind hscan_timing hscan_timing_chk #(
    .DIV    (DIV),
    .N_WIDE (N_WIDE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_strobe (line_strobe),
    .hst         (hst),
    .hck1        (hck1),
    .hck2        (hck2),
    .blank       (blank),
    .side_black  (side_black),
    .vid_pol     (vid_pol),
    .scan_dir    (scan_dir)
);

// File: tb/hscan_timing_tb.sv
module hscan_timing_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_strobe = 1'b0;
    logic wide_sel = 1'b1;
    logic scan_fwd = 1'b1;
    logic hst, hck1, hck2, blank, side_black, vid_pol, scan_dir;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hscan_timing u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_strobe (line_strobe),
        .wide_sel    (wide_sel),
        .scan_fwd    (scan_fwd),
        .hst         (hst),
        .hck1        (hck1),
        .hck2        (hck2),
        .blank       (blank),
        .side_black  (side_black),
        .vid_pol     (vid_pol),
        .scan_dir    (scan_dir)
    );

    // Behavioural line model: position since strobe plus latched settings
    int mk = 100000;
    bit modd = 1'b0;
    bit mwide = 1'b1;
    bit mfwd = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            mk    <= 100000;
            modd  <= 1'b0;
            mwide <= 1'b1;
            mfwd  <= 1'b1;
        end else if (line_strobe) begin
            mk    <= 0;
            modd  <= !modd;
            mwide <= wide_sel;
            mfwd  <= scan_fwd;
        end else if (mk < 100000) begin
            mk <= mk + 1;
        end
    end

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at k=%0d: actual %b expected %b", tag, mk, act, exp);
        end
    endtask

    task automatic compare_all();
        int first_rise = 8 + (modd ? 6 : 0);
        int pulses = mwide ? 357 : 269;
        int last_end = first_rise + 4 * pulses;
        bit in_burst = (mk >= first_rise) && (mk < last_end);
        bit e_hck1 = in_burst && (((mk - first_rise) % 4) < 2);
        bit e_hst = (mk >= first_rise - 2) && (mk < first_rise + 2);
        bit e_blank = !((mk >= first_rise - 2) && (mk < last_end));
        check_bit(mwide ? "R2/R4 hck1" : "R3/R4 hck1", hck1, e_hck1);
        check_bit("R1 hck2", hck2, !e_hck1);
        check_bit("R5 hst", hst, e_hst);
        check_bit("R7 blank", blank, e_blank);
        check_bit("R8 side_black", side_black, !mwide && e_blank);
        check_bit("R6 vid_pol", vid_pol, modd);
        check_bit("R9 scan_dir", scan_dir, mfwd);
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One line: strobe, then len cycles; settings are toggled mid-line (R9)
    task automatic run_line(input bit w, input bit f, input int len, input bit full);
        int rises = 0;
        int first = -1;
        bit prev = 1'b0;
        @(negedge clk);
        compare_all();
        line_strobe = 1'b1;
        wide_sel = w;
        scan_fwd = f;
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            compare_all();
            line_strobe = 1'b0;
            if (j == 20) begin
                wide_sel = !w;
                scan_fwd = !f;
            end
            if (hck1 && !prev) begin
                rises++;
                if (first < 0) first = j;
            end
            prev = hck1;
        end
        if (full) begin
            check_int(w ? "R2 pulse count 16:9" : "R3 pulse count 4:3", rises, w ? 357 : 269);
            check_int("R4 first hck1 rise", first, 8 + (modd ? 6 : 0));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R2: run did not complete, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        // R11: reset values
        repeat (3) @(negedge clk);
        check_bit("R11 hst", hst, 1'b0);
        check_bit("R11 hck1", hck1, 1'b0);
        check_bit("R11 hck2", hck2, 1'b1);
        check_bit("R11 blank", blank, 1'b1);
        check_bit("R11 side_black", side_black, 1'b0);
        check_bit("R11 vid_pol", vid_pol, 1'b0);
        check_bit("R11 scan_dir", scan_dir, 1'b1);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            compare_all();
        end

        run_line(1'b1, 1'b1, 1500, 1'b1);   // 16:9, delayed line
        run_line(1'b1, 1'b0, 1500, 1'b1);   // 16:9, undelayed, reversed
        run_line(1'b0, 1'b1, 1200, 1'b1);   // 4:3, delayed
        run_line(1'b0, 1'b0, 1200, 1'b1);   // 4:3, undelayed
        // R10: strobe mid-line aborts a burst, then a full line follows
        run_line(1'b1, 1'b1, 300, 1'b0);
        run_line(1'b0, 1'b1, 200, 1'b0);
        run_line(1'b1, 1'b0, 1500, 1'b1);
        run_line(1'b0, 1'b1, 1200, 1'b1);

        // R11: reset mid-line returns to the idle state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_bit("R11 hck2 after reset", hck2, 1'b1);
        check_bit("R11 blank after reset", blank, 1'b1);
        check_bit("R11 vid_pol after reset", vid_pol, 1'b0);
        rst_n = 1'b1;
        run_line(1'b1, 1'b1, 1500, 1'b1);
        run_line(1'b0, 1'b0, 1200, 1'b1);
        finish_run();
    end

endmodule